// File: doc/BRIEF.md
# Windowed-Refresh Watchdog Timer

This block is a system watchdog. A 15-bit down-counter starts at 7FFFh and must be reloaded by software before it runs out. Software reloads it by writing two keys in order to the feed register: first 00h, then FFh. If the counter reaches zero and takes one more count, the block either pulses an interrupt or raises a reset request. The system reset controller must then clear that request by asserting reset.

In normal mode the counter is paced by the CPU clock through a prescaler. The prescaler divides by 16 or by 128, or by 2 when the slow sub clock drives the CPU. Counting pauses while the chip sits in stop or wait mode. In protection mode the counter takes one count per pulse of a dedicated low-speed clock-enable input and uses no prescaler. Stop and wait requests do not pause it, and an underflow always produces a reset request. Protection mode comes from a static option pin or from a register bit that software can only set. Static option pins also choose automatic start after reset and the underflow action used in normal mode.

All interfaces are plain control pins and a single-cycle register write port. The block has no data stream, so there is no valid/ready handshake and no back-pressure. A register write is taken in the cycle `reg_wr` is high.

Top module: `wdog_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `count_val` is 7FFFh and both `irq` and `rst_req` are 0.
- R2: In the feed register (address 0), a write of 00h arms the unlock. A write of FFh while armed reloads the counter to 7FFFh on that clock edge. Any other feed write disarms, so an FFh that does not directly follow a 00h does nothing. Writes to other addresses leave the arm state unchanged.
- R3: With `opt_auto_start` = 1 the counter runs from reset. With `opt_auto_start` = 0 it holds 7FFFh until any write to the start register (address 2'd1).
- R4: In normal mode, bit 0 of the control register (address 2'd2) sets the prescaler: 0 gives one count every 16 clocks (the reset value), and 1 gives one count every 128 clocks.
- R5: In normal mode with `sub_clk_sel` = 1, the counter takes one count every 2 clocks, whatever control bit 0 holds.
- R6: In normal mode the counter holds its value in any cycle where `stop_mode` or `wait_mode` is 1.
- R7: In protection mode the counter takes exactly one count per clock in which `prot_tick` is 1. It does not count without `prot_tick`, and `stop_mode` and `wait_mode` have no effect.
- R8: Protection mode is active when `opt_prot_init` = 1, or after a write of bit 0 = 1 to the lock register (address 2'd3). Writing bit 0 = 0 afterwards does not leave protection mode; only reset does.
- R9: A count taken at 0 reloads 7FFFh. In normal mode with `opt_uf_reset` = 0, this gives a one-cycle `irq` pulse in the next cycle. In protection mode, `rst_req` rises in the next cycle instead and stays high until reset.
- R10: If a feed refresh and an underflowing count fall on the same clock edge, the refresh wins. The counter becomes 7FFFh and no interrupt or reset request is produced.
- R11: Outside refresh and underflow, each count lowers `count_val` by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_auto_start | input | 1 | Static: 1 = count from reset, 0 = wait for start write |
| opt_prot_init | input | 1 | Static: 1 = protection mode from reset |
| opt_uf_reset | input | 1 | Static: normal-mode underflow gives reset request (1) or interrupt (0) |
| sub_clk_sel | input | 1 | CPU runs from the sub clock; forces divide-by-2 |
| stop_mode | input | 1 | Chip in stop mode |
| wait_mode | input | 1 | Chip in wait mode |
| prot_tick | input | 1 | One-cycle enable from the dedicated watchdog clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 feed, 1 start, 2 control, 3 lock |
| reg_wdata | input | 8 | Write data |
| count_val | output | CNT_W | Current counter value |
| irq | output | 1 | Underflow interrupt pulse |
| rst_req | output | 1 | Sticky underflow reset request |

## Verification
A refresh and an underflow can land on the same clock edge. The bench sets this up in protection mode with `prot_tick` held high, so the counter moves every cycle. It writes the arming key when the counter reads 1 and the firing key when it reads 0, so the final key meets the count at zero. The collision is judged correct when the counter reads 7FFFh in the next cycle with no reset request or interrupt. A full countdown afterwards must then produce the reset request at the expected point. Random feed-register traffic, checked against an independent model of the unlock, covers the ordering rules around that race.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_FEED = 2'd0,
    WD_GO   = 2'd1,
    WD_CTRL = 2'd2,
    WD_LOCK = 2'd3
  } wd_reg_e;

  localparam logic [7:0] KEY_ARM  = 8'h00;
  localparam logic [7:0] KEY_FIRE = 8'hFF;
endpackage

// File: rtl/wdog_feed.sv
// Two-key unlock for the feed register: arm key then fire key.
module wdog_feed
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] data,
  output logic       refresh
);
  logic armed;

  assign refresh = wr && armed && (data == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (wr) begin
      // only an arm key leaves the sequencer armed; anything else drops it
      armed <= (data == KEY_ARM);
    end
  end
endmodule

// File: rtl/wdog_prescale.sv
// CPU-clock prescaler producing one count enable per divide period.
module wdog_prescale #(
  parameter int DIV_FAST = 16,
  parameter int DIV_SLOW = 128,
  parameter int DIV_SUB  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic slow_sel,
  input  logic sub_sel,
  output logic tick
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ?
                           ((DIV_SLOW > DIV_SUB) ? DIV_SLOW : DIV_SUB) :
                           ((DIV_FAST > DIV_SUB) ? DIV_FAST : DIV_SUB);
  localparam int PW = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic [PW-1:0] pcnt;
  logic [PW-1:0] limit;

  always_comb begin
    if (sub_sel)       limit = PW'(DIV_SUB - 1);
    else if (slow_sel) limit = PW'(DIV_SLOW - 1);
    else               limit = PW'(DIV_FAST - 1);
  end

  // >= so that shrinking the ratio mid-period cannot strand the counter
  assign tick = run && (pcnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (clr) begin
      pcnt <= '0;
    end else if (run) begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_core.sv
// Down-counter with reload, underflow detection and the underflow action.
module wdog_core #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             refresh,
  input  logic             to_reset,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             rst_req
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic uf;

  // refresh takes priority: a count arriving at zero in the same edge is dropped
  assign uf = tick && (count == '0) && !refresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= TOP;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (refresh)     count <= TOP;
      else if (uf)     count <= TOP;
      else if (tick)   count <= count - 1'b1;
      irq     <= uf && !to_reset;
      rst_req <= rst_req || (uf && to_reset);
    end
  end
endmodule

// File: rtl/wdog_top.sv
// Watchdog top: register port, mode logic and count-source selection.
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 15,
  parameter int DIV_FAST = 16,
  parameter int DIV_SLOW = 128,
  parameter int DIV_SUB  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opt_auto_start,
  input  logic             opt_prot_init,
  input  logic             opt_uf_reset,
  input  logic             sub_clk_sel,
  input  logic             stop_mode,
  input  logic             wait_mode,
  input  logic             prot_tick,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [CNT_W-1:0] count_val,
  output logic             irq,
  output logic             rst_req
);
  logic started;
  logic slow_sel;
  logic prot_bit;
  logic prot_act;
  logic halt;
  logic pre_run;
  logic pre_tick;
  logic src_tick;
  logic refresh;
  logic wr_feed;
  logic to_reset;

  assign wr_feed  = reg_wr && (reg_addr == WD_FEED);
  assign prot_act = opt_prot_init || prot_bit;
  assign halt     = !prot_act && (stop_mode || wait_mode);
  assign pre_run  = started && !prot_act && !halt;
  assign src_tick = prot_act ? (started && prot_tick) : pre_tick;
  assign to_reset = prot_act || opt_uf_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started  <= opt_auto_start;
      slow_sel <= 1'b0;
      prot_bit <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == WD_GO)                  started  <= 1'b1;
      if (reg_addr == WD_CTRL)                slow_sel <= reg_wdata[0];
      if (reg_addr == WD_LOCK && reg_wdata[0]) prot_bit <= 1'b1;
    end
  end

  wdog_feed u_feed (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_feed),
    .data    (reg_wdata),
    .refresh (refresh)
  );

  wdog_prescale #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW),
    .DIV_SUB  (DIV_SUB)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (pre_run),
    .clr      (refresh),
    .slow_sel (slow_sel),
    .sub_sel  (sub_clk_sel),
    .tick     (pre_tick)
  );

  wdog_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (src_tick),
    .refresh  (refresh),
    .to_reset (to_reset),
    .count    (count_val),
    .irq      (irq),
    .rst_req  (rst_req)
  );
endmodule

// File: rtl/wdog_top_chk.sv
module wdog_top_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             refresh,
  input logic             src_tick,
  input logic             prot_act,
  input logic             halt,
  input logic             started,
  input logic [CNT_W-1:0] count_val,
  input logic             irq,
  input logic             rst_req
);
  // R9
  rst_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R2
  feed_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (count_val == {CNT_W{1'b1}}));

  // R6
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !refresh) |=> $stable(count_val));

  // R3
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!started && !refresh) |=> $stable(count_val));

  // R11
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_tick && !refresh && count_val != '0) |=>
      (count_val == $past(count_val) - 1'b1));

  // R8
  prot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_act |=> prot_act);

  // R9
  prot_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !$past(prot_act));
endmodule

bind wdog_top wdog_top_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .refresh   (refresh),
  .src_tick  (src_tick),
  .prot_act  (prot_act),
  .halt      (halt),
  .started   (started),
  .count_val (count_val),
  .irq       (irq),
  .rst_req   (rst_req)
);

// File: tb/test_wdog_top.sv
module test_wdog_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opt_auto_start = 1'b0;
  logic        opt_prot_init = 1'b0;
  logic        opt_uf_reset = 1'b0;
  logic        sub_clk_sel = 1'b0;
  logic        stop_mode = 1'b0;
  logic        wait_mode = 1'b0;
  logic        prot_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [14:0] count_val;
  logic        irq;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  int irq_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_top i_wdog_top (
    .clk(clk), .rst_n(rst_n), .opt_auto_start(opt_auto_start),
    .opt_prot_init(opt_prot_init), .opt_uf_reset(opt_uf_reset),
    .sub_clk_sel(sub_clk_sel), .stop_mode(stop_mode), .wait_mode(wait_mode),
    .prot_tick(prot_tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .count_val(count_val), .irq(irq), .rst_req(rst_req)
  );

  always @(negedge clk) if (irq) irq_seen++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit auto_s, input bit prot_i, input bit ufr);
    rst_n = 1'b0;
    opt_auto_start = auto_s; opt_prot_init = prot_i; opt_uf_reset = ufr;
    sub_clk_sel = 0; stop_mode = 0; wait_mode = 0; prot_tick = 0; reg_wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    irq_seen = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_tick();
    prot_tick = 1'b1;
    @(negedge clk);
    prot_tick = 1'b0;
  endtask

  task automatic measure(input int exp, input string req);
    logic [14:0] c;
    int n;
    c = count_val; n = 0;
    while (count_val == c && n < 1000) begin @(negedge clk); n++; end
    c = count_val; n = 0;
    while (count_val == c && n < 1000) begin @(negedge clk); n++; end
    check(n == exp, req, n, exp);
  endtask

  function automatic bit model_fires(input bit arm, input logic [1:0] a, input logic [7:0] d);
    return (a == 2'd0) && arm && (d == 8'hFF);
  endfunction

  function automatic bit model_arm(input bit arm, input logic [1:0] a, input logic [7:0] d);
    return (a != 2'd0) ? arm : (d == 8'h00);
  endfunction

  initial begin
    repeat (180000) @(negedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [14:0] snap;
    bit armed_m;
    bit fire;
    logic [1:0] a;
    logic [7:0] d;
    int n;
    void'($urandom(32'd4711));

    // ---------- normal mode, manual start ----------
    do_reset(1'b0, 1'b0, 1'b0);
    check(count_val == 15'h7FFF, "R1 count", count_val, 15'h7FFF);
    check(irq == 0 && rst_req == 0, "R1 outputs", {irq, rst_req}, 0);
    repeat (40) @(negedge clk);
    check(count_val == 15'h7FFF, "R3 no auto start", count_val, 15'h7FFF);
    wr(2'd1, 8'h5A);
    measure(16, "R4 div16");
    wr(2'd2, 8'h01);
    measure(128, "R4 div128");
    snap = count_val; wait_mode = 1;
    repeat (300) @(negedge clk);
    check(count_val == snap, "R6 wait holds", count_val, snap);
    wait_mode = 0; stop_mode = 1;
    repeat (300) @(negedge clk);
    check(count_val == snap, "R6 stop holds", count_val, snap);
    stop_mode = 0;
    sub_clk_sel = 1;
    measure(2, "R5 sub clock div2");
    wr(2'd0, 8'h00); wr(2'd0, 8'hFF);
    check(count_val == 15'h7FFF, "R2 refresh", count_val, 15'h7FFF);
    n = 0;
    while (!irq && n < 70000) begin @(negedge clk); n++; end
    check(irq == 1, "R9 irq raised", irq, 1);
    check(count_val == 15'h7FFF, "R9 reload after underflow", count_val, 15'h7FFF);
    repeat (5) @(negedge clk);
    check(irq_seen == 1, "R9 irq single cycle", irq_seen, 1);
    check(rst_req == 0, "R9 no reset request", rst_req, 0);

    // ---------- protection from option pin, auto start ----------
    do_reset(1'b1, 1'b1, 1'b0);
    repeat (50) @(negedge clk);
    check(count_val == 15'h7FFF, "R7 no count without prot_tick", count_val, 15'h7FFF);
    stop_mode = 1; wait_mode = 1;
    pulse_tick();
    check(count_val == 15'h7FFE, "R7 one count per tick, stop ignored", count_val, 15'h7FFE);
    stop_mode = 0; wait_mode = 0;
    pulse_tick();
    check(count_val == 15'h7FFD, "R11 step by one", count_val, 15'h7FFD);
    wr(2'd0, 8'h00); wr(2'd0, 8'h3C); wr(2'd0, 8'hFF);
    check(count_val == 15'h7FFD, "R2 broken sequence ignored", count_val, 15'h7FFD);
    wr(2'd0, 8'h00); wr(2'd2, 8'h01); wr(2'd0, 8'hFF);
    check(count_val == 15'h7FFF, "R2 other register keeps arm", count_val, 15'h7FFF);
    armed_m = 0;
    for (int i = 0; i < 80; i++) begin
      if (count_val == 15'h7FFF) pulse_tick();
      case ($urandom % 5)
        0: begin a = 2'd0; d = 8'h00; end
        1: begin a = 2'd0; d = 8'hFF; end
        2: begin a = 2'd0; d = 8'($urandom); end
        default: begin a = 2'(1 + $urandom % 2); d = 8'($urandom); end
      endcase
      fire = model_fires(armed_m, a, d);
      armed_m = model_arm(armed_m, a, d);
      wr(a, d);
      check(count_val == (fire ? 15'h7FFF : 15'h7FFE), "R2 random feed",
            count_val, fire ? 15'h7FFF : 15'h7FFE);
    end

    // ---------- protection from lock bit, collision, forced reset ----------
    do_reset(1'b1, 1'b0, 1'b0);
    wr(2'd3, 8'h01);
    snap = count_val;
    repeat (100) @(negedge clk);
    check(count_val == snap, "R8 lock bit enters protection", count_val, snap);
    wr(2'd3, 8'h00);
    repeat (100) @(negedge clk);
    check(count_val == snap, "R8 lock bit sticky", count_val, snap);
    prot_tick = 1;
    n = 0;
    while (count_val != 15'd1 && n < 40000) begin @(negedge clk); n++; end
    wr(2'd0, 8'h00);
    check(count_val == 15'd0, "R10 reached zero", count_val, 0);
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 8'hFF;
    @(negedge clk);
    reg_wr = 0;
    check(count_val == 15'h7FFF, "R10 refresh wins", count_val, 15'h7FFF);
    check(rst_req == 0, "R10 no reset on collision", rst_req, 0);
    n = 0;
    while (!rst_req && n < 40000) begin @(negedge clk); n++; end
    check(rst_req == 1, "R9 forced reset request", rst_req, 1);
    check(count_val == 15'h7FFF, "R9 reload at reset request", count_val, 15'h7FFF);
    check(irq_seen == 0, "R9 no irq in protection", irq_seen, 0);
    prot_tick = 0;
    repeat (50) @(negedge clk);
    wr(2'd0, 8'h00); wr(2'd0, 8'hFF);
    check(rst_req == 1, "R9 reset request held", rst_req, 1);
    do_reset(1'b1, 1'b0, 1'b0);
    check(rst_req == 0, "R1 reset clears request", rst_req, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule